// File: doc/BRIEF.md
# Sector Write-Buffer Program Sequencer

This block is a clocked behavioural model of the write path of a page-buffered nonvolatile memory. A host writes bytes with active-low chip-enable and write-enable strobes. Each byte goes into a 256-entry sector buffer, and any write that falls outside the sector opened by the first load is dropped. After the host stops writing for a set number of clock cycles, the block runs an internal program cycle. That cycle erases the target sector of a behavioural array and then copies the buffer into it. Any buffer slot that was never written lands as FFh.

The program cycle can take a long time. While it runs, the read path reports status and never returns array data. Bit 7 of a status read is the inverse of bit 7 of the most recently loaded byte. Bit 6 changes on every new read. Software polls either bit until true data comes back. The array keeps a parameterised number of sectors, and the upper sector-address bits fold onto them. This keeps the model small while the full 19-bit address still takes part in sector matching.

Top module: `sector_prog_seq`

## Requirements
- R1: After reset every array byte reads FFh. `dout` is 00h whenever a read is not enabled, meaning `ce_n` high, `oe_n` high or `we_n` low.
- R2: Address bits 18:8 name the sector and bits 7:0 name the byte within it. The array keeps 2^STORE_SECT_W sectors and uses the low STORE_SECT_W sector bits, so sector 9 and sector 1 share storage when STORE_SECT_W is 3.
- R3: Bytes of one sector may be loaded in any order. After the program cycle, every loaded byte reads back with the value last written to it.
- R4: Every byte of the target sector that was not loaded in the window reads FFh after the cycle, including bytes programmed by an earlier cycle.
- R5: The program cycle starts once no write strobe has begun for LOAD_WIN clock cycles after the previous strobe released. A new load inside that window extends the window.
- R6: A write captures its address in the first clock where `ce_n` and `we_n` are both seen low with `oe_n` high, that is, when the later of the two falls. It captures its data in the first clock where either strobe is seen high again.
- R7: The program cycle lasts PROG_CYC clock cycles. After that, reads return true array data.
- R8: During the cycle, any read returns a status byte. Bit 7 is the inverse of bit 7 of the last loaded byte, and bits 5:0 are zero, whatever the address.
- R9: During the cycle, bit 6 of the status byte takes the opposite value on each new read. Once the cycle ends, repeated reads of one address return the same byte.
- R10: A strobe with `oe_n` low, or with either `ce_n` or `we_n` held high, loads nothing and starts no cycle.
- R11: Writes issued while a program cycle runs change neither the array nor the buffer.
- R12: A load to a sector other than the one opened by the window's first load is dropped. `xsect_flag` goes high for exactly one clock for each such load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 19 | Byte address: sector in 18:8, offset in 7:0 |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or status byte, 00h when the read is not enabled |
| xsect_flag | output | 1 | One-clock pulse when a cross-sector load is dropped |

## Verification
A window counter that is off by a few cycles shows up as status bytes appearing too early or too late on reads. The bench therefore samples on both sides of the window edge and on both sides of the end of the program cycle. A corrupted loaded-byte mask or offset latch only becomes visible after the cycle commits. It appears as a wrong byte or a missing FFh somewhere in a full read-back of the sector, roughly LOAD_WIN plus PROG_CYC cycles after the last load. A stuck toggle or a wrong last-byte register shows up on the first two reads of any busy period.

// File: rtl/sps_pkg.sv
package sps_pkg;

  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_ERASE = 2'd2,
    ST_WRITE = 2'd3
  } seq_state_t;

  // status byte seen by a read while the cycle runs
  function automatic logic [DATA_W-1:0] poll_status(input logic [DATA_W-1:0] last_byte,
                                                    input logic tog);
    return {~last_byte[DATA_W-1], tog, {(DATA_W-2){1'b0}}};
  endfunction

endpackage

// File: rtl/sps_strobe.sv
module sps_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic we_n,
  input  logic oe_n,
  output logic wr_start,
  output logic wr_end,
  output logic rd_act,
  output logic rd_start
);
  logic wr_act;
  logic wr_q;
  logic rd_q;

  assign wr_act = ~ce_n & ~we_n & oe_n;
  assign rd_act = ~ce_n & ~oe_n & we_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q <= 1'b0;
      rd_q <= 1'b0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
    end
  end

  assign wr_start = wr_act & ~wr_q;
  assign wr_end   = ~wr_act & wr_q;
  assign rd_start = rd_act & ~rd_q;

endmodule

// File: rtl/sps_loadbuf.sv
module sps_loadbuf #(
  parameter int ADDR_W = 19,
  parameter int OFF_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       accept,
  input  logic                       wr_start,
  input  logic                       wr_end,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [7:0]                 din,
  input  logic                       clear,
  output logic [ADDR_W-OFF_W-1:0]    sect_o,
  output logic                       pend_o,
  output logic                       load_fire_o,
  output logic                       xsect_o,
  output logic [7:0]                 last_o,
  output logic [7:0]                 fill_o [0:(1<<OFF_W)-1]
);
  localparam int SECT_W = ADDR_W - OFF_W;
  localparam int BYTES  = 1 << OFF_W;

  logic [SECT_W-1:0] sect_q;
  logic              have_q;
  logic              pend_q;
  logic [OFF_W-1:0]  off_q;
  logic [BYTES-1:0]  mask_q;
  logic [7:0]        data_q [0:BYTES-1];
  logic [7:0]        last_q;
  logic              xsect_q;
  logic              same_sect;

  assign same_sect   = (addr[ADDR_W-1:OFF_W] == sect_q);
  assign load_fire_o = wr_end & pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sect_q  <= '0;
      have_q  <= 1'b0;
      pend_q  <= 1'b0;
      off_q   <= '0;
      mask_q  <= '0;
      last_q  <= '0;
      xsect_q <= 1'b0;
    end else begin
      xsect_q <= 1'b0;
      if (clear) begin
        mask_q <= '0;
        have_q <= 1'b0;
      end
      if (wr_start && accept) begin
        if (!have_q || same_sect) begin
          pend_q <= 1'b1;
          off_q  <= addr[OFF_W-1:0];
          if (!have_q) begin
            sect_q <= addr[ADDR_W-1:OFF_W];
            have_q <= 1'b1;
          end
        end else begin
          xsect_q <= 1'b1;
        end
      end
      if (load_fire_o) begin
        mask_q[off_q] <= 1'b1;
        last_q        <= din;
        pend_q        <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (load_fire_o) data_q[off_q] <= din;
  end

  always_comb begin
    for (int i = 0; i < BYTES; i++) fill_o[i] = mask_q[i] ? data_q[i] : 8'hFF;
  end

  assign sect_o  = sect_q;
  assign pend_o  = pend_q;
  assign xsect_o = xsect_q;
  assign last_o  = last_q;

  // loads while busy leave the buffer untouched
  assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !clear) |=> $stable(mask_q));
  // a dropped cross-sector load never marks a byte
  assert_xsect_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    xsect_q |-> $stable(mask_q));

endmodule

// File: rtl/sps_seq.sv
module sps_seq
  import sps_pkg::*;
#(
  parameter int LOAD_WIN = 64,
  parameter int PROG_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_fire,
  input  logic hold,
  output logic busy_o,
  output logic accept_o,
  output logic erase_go_o,
  output logic commit_o
);
  localparam int WIN_W     = $clog2(LOAD_WIN + 1);
  localparam int PRG_W     = $clog2(PROG_CYC + 1);
  localparam int ERASE_CYC = PROG_CYC / 2;

  seq_state_t       state;
  logic [WIN_W-1:0] win_cnt;
  logic [PRG_W-1:0] prog_cnt;
  logic             timeout;

  assign timeout    = (state == ST_LOAD) && !load_fire && !hold &&
                      (win_cnt == WIN_W'(LOAD_WIN));
  assign erase_go_o = timeout;
  assign commit_o   = (state == ST_WRITE) && (prog_cnt == PRG_W'(PROG_CYC - 1));
  assign busy_o     = (state == ST_ERASE) || (state == ST_WRITE);
  assign accept_o   = !busy_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      win_cnt  <= '0;
      prog_cnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (load_fire) begin
          state   <= ST_LOAD;
          win_cnt <= '0;
        end
        ST_LOAD: begin
          if (load_fire)   win_cnt <= '0;
          else if (timeout) begin
            state    <= ST_ERASE;
            prog_cnt <= '0;
          end else if (!hold) win_cnt <= win_cnt + 1'b1;
        end
        ST_ERASE: begin
          prog_cnt <= prog_cnt + 1'b1;
          if (prog_cnt == PRG_W'(ERASE_CYC - 1)) state <= ST_WRITE;
        end
        ST_WRITE: begin
          prog_cnt <= prog_cnt + 1'b1;
          if (commit_o) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_win_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOAD) |-> (win_cnt <= WIN_W'(LOAD_WIN)));
  assert_prog_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && $past(state == ST_WRITE)) |-> ($past(prog_cnt) == PRG_W'(PROG_CYC - 1)));

endmodule

// File: rtl/sps_array.sv
module sps_array #(
  parameter int OFF_W        = 8,
  parameter int STORE_SECT_W = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [STORE_SECT_W-1:0]       row,
  input  logic                          erase_go,
  input  logic                          commit,
  input  logic [7:0]                    fill [0:(1<<OFF_W)-1],
  input  logic [STORE_SECT_W+OFF_W-1:0] rd_idx,
  output logic [7:0]                    rd_data
);
  localparam int BYTES = 1 << OFF_W;
  localparam int DEPTH = 1 << (STORE_SECT_W + OFF_W);

  logic [7:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (erase_go) begin
      for (int i = 0; i < BYTES; i++) mem[{row, OFF_W'(i)}] <= 8'hFF;
    end else if (commit) begin
      for (int i = 0; i < BYTES; i++) mem[{row, OFF_W'(i)}] <= fill[i];
    end
  end

  assign rd_data = mem[rd_idx];

endmodule

// File: rtl/sector_prog_seq.sv
module sector_prog_seq
  import sps_pkg::*;
#(
  parameter int ADDR_W       = 19,
  parameter int OFF_W        = 8,
  parameter int STORE_SECT_W = 3,
  parameter int LOAD_WIN     = 64,
  parameter int PROG_CYC     = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              xsect_flag
);
  localparam int SECT_W = ADDR_W - OFF_W;
  localparam int IDX_W  = STORE_SECT_W + OFF_W;
  localparam int BYTES  = 1 << OFF_W;

  logic              wr_start, wr_end, rd_act, rd_start;
  logic              busy, accept, erase_go, commit;
  logic              pend, load_fire, xsect;
  logic [SECT_W-1:0] sect;
  logic [7:0]        last_byte;
  logic [7:0]        fill [0:BYTES-1];
  logic [7:0]        arr_rd;
  logic              tog_q;

  sps_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .wr_start(wr_start), .wr_end(wr_end), .rd_act(rd_act), .rd_start(rd_start)
  );

  sps_loadbuf #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .accept(accept), .wr_start(wr_start), .wr_end(wr_end),
    .addr(addr), .din(din), .clear(commit), .sect_o(sect), .pend_o(pend),
    .load_fire_o(load_fire), .xsect_o(xsect), .last_o(last_byte), .fill_o(fill)
  );

  sps_seq #(.LOAD_WIN(LOAD_WIN), .PROG_CYC(PROG_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .load_fire(load_fire), .hold(pend | wr_start),
    .busy_o(busy), .accept_o(accept), .erase_go_o(erase_go), .commit_o(commit)
  );

  sps_array #(.OFF_W(OFF_W), .STORE_SECT_W(STORE_SECT_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .row(sect[STORE_SECT_W-1:0]), .erase_go(erase_go),
    .commit(commit), .fill(fill), .rd_idx(addr[IDX_W-1:0]), .rd_data(arr_rd)
  );

  // toggle bit advances once per read that begins during the cycle
  always_ff @(posedge clk) begin
    if (!rst_n)                tog_q <= 1'b0;
    else if (busy && rd_start) tog_q <= ~tog_q;
  end

  assign dout       = rd_act ? (busy ? poll_status(last_byte, tog_q) : arr_rd) : 8'h00;
  assign xsect_flag = xsect;

  assert_read_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n || !we_n) |-> (dout == 8'h00));
  assert_poll_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_act) |-> (dout[5:0] == 6'd0 && dout[7] == ~last_byte[7]));

endmodule

// File: tb/sector_prog_seq_tb.sv
module sector_prog_seq_tb_top;
  localparam int LOAD_WIN = 64;
  localparam int PROG_CYC = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [18:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        xsect_flag;

  int nchk = 0, nfail = 0, cyc = 0, xs_cnt = 0;
  bit done = 0;
  logic [7:0] model [0:2047];

  sector_prog_seq #(.LOAD_WIN(LOAD_WIN), .PROG_CYC(PROG_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .xsect_flag(xsect_flag)
  );

  always #10 clk = ~clk;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (xsect_flag) xs_cnt <= xs_cnt + 1;
  end

  function automatic logic [18:0] mk(input int s, input int o);
    return {11'(s), 8'(o)};
  endfunction
  function automatic int midx(input logic [18:0] a);
    return int'(a[10:0]);
  endfunction
  function automatic logic [7:0] exp_poll(input logic [7:0] last_b);
    return {~last_b[7], 7'd0};
  endfunction

  task automatic chk(input string r, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h at cycle %0d", r, act, exp, cyc);
    end
  endtask

  task automatic wgen(input logic [18:0] a, input logic [7:0] d,
                      input logic c, input logic w, input logic o);
    @(negedge clk); addr = a; din = d; ce_n = c; we_n = w; oe_n = o;
    @(negedge clk); @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [18:0] a, input logic [7:0] d);
    wgen(a, d, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic rd(input logic [18:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    @(negedge clk); @(negedge clk);
    d = dout;
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic verify_sector(input int s, input string r);
    logic [7:0] v;
    for (int o = 0; o < 256; o++) begin
      rd(mk(s, o), v);
      chk(r, v, model[midx(mk(s, o))]);
    end
  endtask

  // random-order load of n bytes, poll checks, then full read-back
  task automatic prog_round(input int s, input int n);
    int perm [0:255];
    logic [7:0] stage [0:255];
    bit ld [0:255];
    logic [7:0] last_b, p1, p2;
    int t_rel;
    for (int i = 0; i < 256; i++) begin perm[i] = i; ld[i] = 0; stage[i] = 8'hFF; end
    for (int i = 255; i > 0; i--) begin
      int j, tmp;
      j = int'($urandom % (i + 1));
      tmp = perm[i]; perm[i] = perm[j]; perm[j] = tmp;
    end
    last_b = 8'h00;
    for (int k = 0; k < n; k++) begin
      last_b = 8'($urandom);
      stage[perm[k]] = last_b; ld[perm[k]] = 1;
      wr(mk(s, perm[k]), last_b);
    end
    t_rel = cyc;
    wait_until(t_rel + LOAD_WIN + 4);
    rd(mk(s, perm[0]), p1);
    chk("R8 poll bits", p1 & 8'hBF, exp_poll(last_b));
    rd(mk(s, 17), p2);
    chk("R8 poll any addr", p2 & 8'hBF, exp_poll(last_b));
    chk("R9 toggle", {7'd0, p2[6]}, {7'd0, ~p1[6]});
    wait_until(t_rel + LOAD_WIN + PROG_CYC + 8);
    for (int o = 0; o < 256; o++) model[midx(mk(s, o))] = ld[o] ? stage[o] : 8'hFF;
    verify_sector(s, "R3/R4 readback");
  endtask

  initial begin
    logic [7:0] v, v2;
    int t_rel;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 2048; i++) model[i] = 8'hFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state and read gating
    chk("R1 gate idle", dout, 8'h00);
    rd(mk(0, 5), v);  chk("R1 erased", v, 8'hFF);
    rd(mk(6, 200), v); chk("R1 erased", v, 8'hFF);

    // R5 window extension and timing, R7 duration, R8/R9 polls
    wr(mk(7, 10), 8'hA5);
    repeat (LOAD_WIN - 10) @(negedge clk);
    wr(mk(7, 200), 8'h96);
    t_rel = cyc;
    wait_until(t_rel + LOAD_WIN - 6);
    rd(mk(6, 0), v);  chk("R5 not yet started", v, 8'hFF);
    wait_until(t_rel + LOAD_WIN + 4);
    rd(mk(6, 0), v);  chk("R5 started, R8 status", v & 8'hBF, 8'h00);
    rd(mk(6, 0), v2); chk("R9 toggle", {7'd0, v2[6]}, {7'd0, ~v[6]});
    wait_until(t_rel + LOAD_WIN + PROG_CYC - 8);
    rd(mk(6, 0), v);  chk("R7 still busy", v & 8'hBF, 8'h00);
    wait_until(t_rel + LOAD_WIN + PROG_CYC + 8);
    rd(mk(6, 0), v);  chk("R7 true data", v, 8'hFF);
    rd(mk(7, 10), v); chk("R5 extended window", v, 8'hA5);
    rd(mk(7, 10), v2); chk("R9 stable after", v2, v);
    rd(mk(7, 200), v); chk("R3 second byte", v, 8'h96);
    rd(mk(7, 11), v); chk("R4 unloaded", v, 8'hFF);
    model[midx(mk(7, 10))] = 8'hA5; model[midx(mk(7, 200))] = 8'h96;

    // random rounds, R3/R4/R8/R9
    prog_round(2, 256);
    prog_round(3, 1 + int'($urandom % 40));
    prog_round(5, 1 + int'($urandom % 255));
    prog_round(2, 1 + int'($urandom % 30));  // reprogram: earlier bytes must erase (R4)

    // R11 loads during the cycle are ignored
    wr(mk(4, 0), 8'h3C);
    t_rel = cyc;
    wait_until(t_rel + LOAD_WIN + 6);
    wr(mk(4, 1), 8'h11);
    wr(mk(6, 3), 8'h12);
    wait_until(t_rel + LOAD_WIN + PROG_CYC + 8);
    model[midx(mk(4, 0))] = 8'h3C;
    rd(mk(4, 0), v); chk("R11 first byte", v, 8'h3C);
    rd(mk(4, 1), v); chk("R11 busy load ignored", v, model[midx(mk(4, 1))]);
    rd(mk(6, 3), v); chk("R11 busy load ignored", v, model[midx(mk(6, 3))]);

    // R12 cross-sector load dropped and flagged
    begin
      int xs0;
      xs0 = xs_cnt;
      wr(mk(1, 1), 8'h33);
      wr(mk(6, 1), 8'h44);
      wr(mk(1, 2), 8'h55);
      chk("R12 flag pulses", 8'(xs_cnt - xs0), 8'd1);
      t_rel = cyc;
      wait_until(t_rel + LOAD_WIN + PROG_CYC + 8);
      for (int o = 0; o < 256; o++) model[midx(mk(1, o))] = 8'hFF;
      model[midx(mk(1, 1))] = 8'h33; model[midx(mk(1, 2))] = 8'h55;
      rd(mk(6, 1), v); chk("R12 dropped byte", v, model[midx(mk(6, 1))]);
      verify_sector(1, "R12 own sector");
    end

    // R10 inhibited strobes
    wgen(mk(0, 9), 8'h01, 1'b0, 1'b0, 1'b0);
    wgen(mk(0, 9), 8'h02, 1'b1, 1'b0, 1'b1);
    wgen(mk(0, 9), 8'h03, 1'b0, 1'b1, 1'b1);
    repeat (LOAD_WIN + 20) @(negedge clk);
    rd(mk(0, 9), v); chk("R10 no load, no cycle", v, model[midx(mk(0, 9))]);
    chk("R10 gate idle", dout, 8'h00);

    // R6 address at later falling strobe, data at first rising strobe
    @(negedge clk); addr = mk(0, 40); din = 8'h77; ce_n = 1'b0;
    @(negedge clk); addr = mk(0, 41); we_n = 1'b0;
    @(negedge clk); @(negedge clk); we_n = 1'b1;
    @(negedge clk); din = 8'h88;
    @(negedge clk); ce_n = 1'b1;
    @(negedge clk);
    t_rel = cyc;
    wait_until(t_rel + LOAD_WIN + PROG_CYC + 8);
    for (int o = 0; o < 256; o++) model[midx(mk(0, o))] = 8'hFF;
    model[midx(mk(0, 41))] = 8'h77;
    rd(mk(0, 41), v); chk("R6 addr and data", v, 8'h77);
    rd(mk(0, 40), v); chk("R6 early addr unused", v, 8'hFF);

    // R2 upper sector bits fold onto stored rows
    wr(mk(8 + 3, 7), 8'h5A);
    t_rel = cyc;
    wait_until(t_rel + LOAD_WIN + PROG_CYC + 8);
    for (int o = 0; o < 256; o++) model[midx(mk(3, o))] = 8'hFF;
    model[midx(mk(3, 7))] = 8'h5A;
    rd(mk(3, 7), v);  chk("R2 alias read", v, 8'h5A);
    rd(mk(11, 7), v); chk("R2 full address read", v, 8'h5A);
    rd(mk(3, 8), v);  chk("R2 sector erased", v, 8'hFF);

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

endmodule